// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block produces the timing frame of a simple 8-bit processor bus. It halves an oscillator input to create a processor clock with an even duty cycle. It then counts T-states, one per processor clock period, through each machine cycle. A requester supplies the kind of cycle it wants and how many T-states to add beyond the minimum of three. For the whole of that cycle, the sequencer places a three-bit status code on its IO/memory, S1 and S0 outputs. It also reports the current T-state number and flags the final T-state.

All logic runs on the oscillator clock. The processor clock is a register output, and every change of sequencer state happens on the oscillator edge that raises the processor clock. A new cycle can follow the previous one directly, with no gap. If no request is waiting, the sequencer drops back to idle.

Top module: `busSeqTop`

## Requirements
- R1: `procClk` is low after reset and inverts on every rising edge of `oscClk`, so one processor clock period equals two oscillator periods and the duty cycle is 50%.
- R2: `tState` reads 0 when idle. Within a cycle it counts 1, 2, 3 and so on, one step at each rising edge of `procClk`, and each value is held for exactly one `procClk` period.
- R3: For every kind of cycle except opcode fetch, the cycle length in T-states is 3 plus the 2-bit `reqExtra`, which gives 3 to 6.
- R4: An opcode fetch (`reqType`=0) lasts max(4, 3+`reqExtra`) T-states, which is never fewer than 4.
- R5: The status code {`ioNotMem`,`stat1`,`stat0`} depends on `reqType`: 0 opcode fetch gives 011, 1 memory read gives 010, 2 memory write gives 001, 3 I/O read gives 110, 4 I/O write gives 101.
- R6: The status outputs change only at the rising `procClk` edge that begins T1. They hold their value through every later T-state of that cycle.
- R7: `cycleDone` is high throughout the last T-state of a cycle and low at every other time.
- R8: A request is taken on a rising `procClk` edge when the sequencer is idle or is in its last T-state. A request taken in the last T-state starts T1 on the very next rising edge, with no idle T-state in between.
- R9: If no valid request is present at the end of a cycle, the sequencer returns to idle on the next rising `procClk` edge: `tState`=0, status 000 and `cycleDone`=0.
- R10: A request with `reqType` 5, 6 or 7 is ignored. The sequencer stays idle and all outputs keep their idle values.
- R11: A synchronous `rst` stops any cycle in progress. On the following clock it returns the sequencer to idle with `procClk` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A cycle request is present |
| reqType | input | 3 | Kind of cycle: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| reqExtra | input | 2 | Number of T-states added to the base length of 3 |
| procClk | output | 1 | Processor clock, oscillator divided by two |
| ioNotMem | output | 1 | Status: 1 for an I/O cycle, 0 for a memory cycle or idle |
| stat1 | output | 1 | Status bit S1 |
| stat0 | output | 1 | Status bit S0 |
| tState | output | 3 | Current T-state number, 0 when idle |
| cycleDone | output | 1 | High during the last T-state of a cycle |

## Verification
Every result appears on the oscillator edge that raises `procClk`, one register stage after the request is sampled. T1 and its status code are therefore visible in the half period right after the tick edge that accepted the request. The bench finds the tick edge by watching `procClk` low at an oscillator falling edge. It drives the request at that falling edge. It then samples both half periods of every T-state at falling edges, so each check falls between two register updates. The sweep covers all five kinds and all four extra counts, chained cycles, rejected codes and a mid-cycle reset. Expected lengths and codes are computed from R3 to R5.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  // Kinds of machine cycle, encoded as on reqType
  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MEMRD = 3'd1,
    CYC_MEMWR = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4
  } cycKind_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic load;     // begin T1 of a new cycle
    logic advance;  // step to the next T-state
    logic clear;    // go back to idle
  } seqStrobe_t;

  // Status code {ioNotMem, s1, s0} for a cycle kind
  function automatic logic [2:0] statusFor(input logic [2:0] kind);
    logic [2:0] code;
    case (kind)
      CYC_FETCH: code = 3'b011;
      CYC_MEMRD: code = 3'b010;
      CYC_MEMWR: code = 3'b001;
      CYC_IORD:  code = 3'b110;
      CYC_IOWR:  code = 3'b101;
      default:   code = 3'b000;
    endcase
    return code;
  endfunction

  function automatic logic kindValid(input logic [2:0] kind);
    return kind <= CYC_IOWR;
  endfunction

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic       oscClk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [2:0] reqType,
  input  logic       busy,
  input  logic       lastT,
  output logic       procClk,
  output seqStrobe_t strobe
);

  logic phase;
  logic tick;
  logic reqOk;

  // Divide by two: phase inverts on every oscillator edge
  always_ff @(posedge oscClk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  // State moves on the edge where procClk rises
  assign tick    = ~phase;
  assign procClk = phase;
  assign reqOk   = reqValid && kindValid(reqType);

  always_comb begin
    strobe         = '0;
    strobe.load    = !rst && tick && reqOk && (!busy || lastT);
    strobe.advance = !rst && tick && busy && !lastT;
    strobe.clear   = !rst && tick && busy && lastT && !reqOk;
  end

endmodule

// File: rtl/busSeqData.sv
module busSeqData
  import busSeqPkg::*;
#(
  parameter int EXTRA_W  = 2,
  parameter int BASE_LEN = 3,
  parameter int FETCH_MIN = 4,
  parameter int TSTATE_W = 3
) (
  input  logic                oscClk,
  input  logic                rst,
  input  seqStrobe_t          strobe,
  input  logic [2:0]          reqType,
  input  logic [EXTRA_W-1:0]  reqExtra,
  output logic                busy,
  output logic                lastT,
  output logic [TSTATE_W-1:0] tCount,
  output logic [2:0]          status
);

  logic [TSTATE_W-1:0] cycLen;
  logic [TSTATE_W-1:0] reqLen;

  // Length of the requested cycle, with the fetch minimum applied
  always_comb begin
    reqLen = TSTATE_W'(BASE_LEN) + TSTATE_W'(reqExtra);
    if (reqType == CYC_FETCH && reqLen < TSTATE_W'(FETCH_MIN))
      reqLen = TSTATE_W'(FETCH_MIN);
  end

  always_ff @(posedge oscClk) begin
    if (rst) begin
      tCount <= '0;
      cycLen <= '0;
      status <= '0;
    end else if (strobe.load) begin
      tCount <= TSTATE_W'(1);
      cycLen <= reqLen;
      status <= statusFor(reqType);
    end else if (strobe.advance) begin
      tCount <= tCount + TSTATE_W'(1);
    end else if (strobe.clear) begin
      tCount <= '0;
      cycLen <= '0;
      status <= '0;
    end
  end

  assign busy  = tCount != '0;
  assign lastT = busy && (tCount == cycLen);

endmodule

// File: rtl/busSeqTop.sv
module busSeqTop
  import busSeqPkg::*;
#(
  parameter int EXTRA_W   = 2,
  parameter int BASE_LEN  = 3,
  parameter int FETCH_MIN = 4,
  localparam int MAX_LEN  = BASE_LEN + (1 << EXTRA_W) - 1,
  localparam int TSTATE_W = $clog2(MAX_LEN + 1)
) (
  input  logic                oscClk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [2:0]          reqType,
  input  logic [EXTRA_W-1:0]  reqExtra,
  output logic                procClk,
  output logic                ioNotMem,
  output logic                stat1,
  output logic                stat0,
  output logic [TSTATE_W-1:0] tState,
  output logic                cycleDone
);

  seqStrobe_t strobe;
  logic       busy;
  logic       lastT;
  logic [2:0] status;

  busSeqCtrl u_ctrl (
    .oscClk  (oscClk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqType (reqType),
    .busy    (busy),
    .lastT   (lastT),
    .procClk (procClk),
    .strobe  (strobe)
  );

  busSeqData #(
    .EXTRA_W  (EXTRA_W),
    .BASE_LEN (BASE_LEN),
    .FETCH_MIN(FETCH_MIN),
    .TSTATE_W (TSTATE_W)
  ) u_data (
    .oscClk  (oscClk),
    .rst     (rst),
    .strobe  (strobe),
    .reqType (reqType),
    .reqExtra(reqExtra),
    .busy    (busy),
    .lastT   (lastT),
    .tCount  (tState),
    .status  (status)
  );

  assign {ioNotMem, stat1, stat0} = status;
  assign cycleDone = lastT;

endmodule

// File: rtl/busSeqChecker.sv
module busSeqChecker #(
  parameter int TSTATE_W = 3,
  parameter int MAX_LEN  = 6,
  parameter int BASE_LEN = 3,
  parameter int FETCH_MIN = 4
) (
  input logic                oscClk,
  input logic                rst,
  input logic                procClk,
  input logic                ioNotMem,
  input logic                stat1,
  input logic                stat0,
  input logic [TSTATE_W-1:0] tState,
  input logic                cycleDone
);

  // R1: processor clock inverts on every oscillator edge
  assert_clk_toggle_R1: assert property (@(posedge oscClk) disable iff (rst || $past(rst))
    procClk != $past(procClk));

  // R2: T-state steps by one at the tick edge while not in the last state
  assert_tstate_step_R2: assert property (@(posedge oscClk) disable iff (rst || $past(rst))
    (!procClk && tState != '0 && !cycleDone) |=> (tState == $past(tState) + TSTATE_W'(1)));

  // R3: T-state number never exceeds the longest cycle
  assert_tstate_bound_R3: assert property (@(posedge oscClk) disable iff (rst)
    tState <= TSTATE_W'(MAX_LEN));

  // R4: an opcode fetch never ends before its minimum length
  assert_fetch_min_R4: assert property (@(posedge oscClk) disable iff (rst)
    (cycleDone && !ioNotMem && stat1 && stat0) |-> (tState >= TSTATE_W'(FETCH_MIN)));

  // R6: status is steady after T1
  assert_status_hold_R6: assert property (@(posedge oscClk) disable iff (rst || $past(rst))
    (tState > TSTATE_W'(1)) |-> $stable({ioNotMem, stat1, stat0}));

  // R7: cycle end only after the base length
  assert_done_len_R7: assert property (@(posedge oscClk) disable iff (rst)
    cycleDone |-> (tState >= TSTATE_W'(BASE_LEN)));

  // R9: idle carries the zero status code and no done flag
  assert_idle_code_R9: assert property (@(posedge oscClk) disable iff (rst)
    (tState == '0) |-> ({ioNotMem, stat1, stat0} == 3'b000 && !cycleDone));

endmodule

bind busSeqTop busSeqChecker #(
  .TSTATE_W (TSTATE_W),
  .MAX_LEN  (MAX_LEN),
  .BASE_LEN (BASE_LEN),
  .FETCH_MIN(FETCH_MIN)
) u_busSeqChecker (
  .oscClk   (oscClk),
  .rst      (rst),
  .procClk  (procClk),
  .ioNotMem (ioNotMem),
  .stat1    (stat1),
  .stat0    (stat0),
  .tState   (tState),
  .cycleDone(cycleDone)
);

// File: tb/tb_busSeqTop.sv
`timescale 1ns/1ps
module tb_busSeqTop;

  logic       oscClk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic [2:0] reqType = 3'd0;
  logic [1:0] reqExtra = 2'd0;
  logic       procClk, ioNotMem, stat1, stat0, cycleDone;
  logic [2:0] tState;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 oscClk = ~oscClk;

  busSeqTop dut (
    .oscClk(oscClk), .rst(rst), .reqValid(reqValid), .reqType(reqType),
    .reqExtra(reqExtra), .procClk(procClk), .ioNotMem(ioNotMem),
    .stat1(stat1), .stat0(stat0), .tState(tState), .cycleDone(cycleDone)
  );

  function automatic int expLen(input int t, input int e);
    int n = 3 + e;
    if (t == 0 && n < 4) n = 4;
    return n;
  endfunction

  function automatic logic [2:0] expCode(input int t);
    logic io = (t == 3 || t == 4);
    logic s1 = (t == 0 || t == 1 || t == 3);
    logic s0 = (t == 0 || t == 2 || t == 4);
    return {io, s1, s0};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Wait for the falling oscillator edge just before a tick edge
  task automatic waitTick();
    @(negedge oscClk);
    while (procClk !== 1'b0) @(negedge oscClk);
  endtask

  task automatic setReq(input logic v, input int t, input int e);
    reqValid = v;
    reqType  = 3'(t);
    reqExtra = 2'(e);
  endtask

  // Follow one cycle from T1; optionally chain another request at its end
  task automatic follow(input int t, input int e, input bit chain, input int ct, input int ce);
    int n = expLen(t, e);
    for (int k = 1; k <= n; k++) begin
      @(negedge oscClk);
      check("R1 procClk high half", 8'(procClk), 8'd1);
      check((t == 0) ? "R4 tState" : "R2/R3 tState", 8'(tState), 8'(k));
      check((k == 1) ? "R5 status" : "R6 status hold", 8'({ioNotMem, stat1, stat0}), 8'(expCode(t)));
      check("R7 cycleDone", 8'(cycleDone), 8'(k == n));
      if (k == 1) setReq(1'b0, 0, 0);
      @(negedge oscClk);
      check("R1 procClk low half", 8'(procClk), 8'd0);
      check("R2 tState held", 8'(tState), 8'(k));
      check("R7 cycleDone held", 8'(cycleDone), 8'(k == n));
      if (k == n && chain) setReq(1'b1, ct, ce);
    end
  endtask

  task automatic expectIdle(input string req);
    @(negedge oscClk);
    check(req, 8'(tState), 8'd0);
    check(req, 8'({ioNotMem, stat1, stat0}), 8'd0);
    check(req, 8'(cycleDone), 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge oscClk);
    check("R11 reset tState", 8'(tState), 8'd0);
    check("R11 reset procClk", 8'(procClk), 8'd0);
    check("R11 reset status", 8'({ioNotMem, stat1, stat0}), 8'd0);
    rst = 1'b0;
    @(negedge oscClk);
    check("R1 first rise", 8'(procClk), 8'd1);

    // Sweep every kind and extra count from idle
    for (int t = 0; t < 5; t++) begin
      for (int e = 0; e < 4; e++) begin
        waitTick();
        setReq(1'b1, t, e);
        follow(t, e, 1'b0, 0, 0);
        expectIdle("R9 idle after cycle");
      end
    end

    // Back-to-back cycles with no idle gap
    waitTick();
    setReq(1'b1, 0, 0);
    follow(0, 0, 1'b1, 1, 2);
    follow(1, 2, 1'b1, 4, 3);
    follow(4, 3, 1'b1, 2, 0);
    follow(2, 0, 1'b0, 0, 0);
    expectIdle("R8/R9 idle after chain");

    // Rejected kind codes
    for (int t = 5; t < 8; t++) begin
      waitTick();
      setReq(1'b1, t, 1);
      expectIdle("R10 rejected kind");
      expectIdle("R10 rejected kind");
      setReq(1'b0, 0, 0);
    end

    // Reset in the middle of a cycle
    waitTick();
    setReq(1'b1, 3, 3);
    repeat (4) @(negedge oscClk);
    setReq(1'b0, 0, 0);
    check("R8 mid cycle", 8'(tState), 8'd2);
    rst = 1'b1;
    @(negedge oscClk);
    check("R11 reset idles", 8'(tState), 8'd0);
    check("R11 reset clock", 8'(procClk), 8'd0);
    check("R11 reset status", 8'({ioNotMem, stat1, stat0}), 8'd0);
    rst = 1'b0;
    expectIdle("R11 idle after reset");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule